// File: doc/BRIEF.md
# Rotor Position Stepping Counter

This block keeps the rotational position of every rotor in a rotor cipher machine. Each position is a 5-bit value that counts modulo 26. The block works in two phases. In the set phase, one rotor is addressed on every clock. It either takes a new position from an input or moves on by one. In the encode phase, the rotors move only when the encode controller sends a one-cycle step pulse. That pulse comes once per character, before the wheel lookups start.

Stepping in the encode phase works like an odometer. A wheel-order input maps each stage (stage 0 is the fastest) to a physical rotor. A wheel-count input says how many stages are active. Stage 0 moves on every step. Each later active stage moves only when the stage before it rolls from 25 to 0 on that same step.

During the wheel passes, a stage-select input chooses a stage. The block then shows, without any added cycle, which physical rotor sits at that stage and the current position of that rotor.

Top module: `rotor_pos_counter`

## Requirements
- R1: While reset is asserted (rst_n low), every rotor position is 0.
- R2: When set_mode is 1 and set_load is 1 and set_pos is below 26, the rotor numbered set_wheel takes set_pos on the next clock. No other rotor changes.
- R3: When set_mode is 1 and set_load is 1 and set_pos is 26 or more, the addressed rotor keeps its position.
- R4: When set_mode is 1 and set_load is 0, the addressed rotor advances by one on every clock, going from 25 to 0.
- R5: While set_mode is 1, the step input has no effect on any rotor.
- R6: When set_mode is 0 and num_wheels is at least 1, a clock with step high advances the stage-0 rotor by one modulo 26. A clock with step low changes no rotor.
- R7: A stage k above 0 advances on a step only if stage k-1 goes from 25 to 0 on that same step. Stage k then also advances by one modulo 26.
- R8: Stages numbered num_wheels or higher never advance in the encode phase. When num_wheels is 0, no rotor advances.
- R9: cur_wheel equals wheel_ord field sel (bits sel*2 to sel*2+1). cur_pos is the position of that rotor. Both follow sel in the same cycle.
- R10: Every rotor position stays below 26 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| set_mode | input | 1 | 1 = set phase, 0 = encode phase |
| set_wheel | input | 2 | Physical rotor addressed in the set phase |
| set_load | input | 1 | Set phase: 1 = load set_pos, 0 = advance by one |
| set_pos | input | 5 | Position to load |
| step | input | 1 | One-cycle advance request per encoded character |
| num_wheels | input | 3 | Number of active stages, 0 to 4 |
| wheel_ord | input | 8 | Field k (2 bits) is the physical rotor used at stage k |
| sel | input | 2 | Stage shown on the outputs |
| cur_wheel | output | 2 | Physical rotor at stage sel |
| cur_pos | output | 5 | Position of that rotor |

## Verification
The bench preloads several rotors with 25 and then steps. A carry chain that skips a stage, carries on 26 instead of 25, or ignores num_wheels shows up as a later rotor that moves too often, too rarely, or at all. Out-of-range loads are mixed in with valid ones: a block that stores them, or reduces them modulo 26, leaves a wrong position behind. Step pulses arrive during the set phase, and sel and wheel_ord are swept over every stage. Any leak between the phases, or any mix-up between stage and physical rotor, therefore produces a wrong cur_wheel or cur_pos.

// File: rtl/rotor_pos_counter.sv
module rotor_pos_counter #(
  parameter int NUM_ROT = 4,
  parameter int POS_W   = 5,
  parameter int MODULUS = 26,
  localparam int IDX_W  = $clog2(NUM_ROT),
  localparam int CNT_W  = $clog2(NUM_ROT + 1)
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic                     set_mode,
  input  logic [IDX_W-1:0]         set_wheel,
  input  logic                     set_load,
  input  logic [POS_W-1:0]         set_pos,
  input  logic                     step,
  input  logic [CNT_W-1:0]         num_wheels,
  input  logic [NUM_ROT*IDX_W-1:0] wheel_ord,
  input  logic [IDX_W-1:0]         sel,
  output logic [IDX_W-1:0]         cur_wheel,
  output logic [POS_W-1:0]         cur_pos
);
  localparam logic [POS_W-1:0] LAST = POS_W'(MODULUS - 1);

  logic [POS_W-1:0] pos_q [NUM_ROT];
  logic [NUM_ROT-1:0] stage_adv, rot_adv;

  function automatic logic [POS_W-1:0] bump(input logic [POS_W-1:0] v);
    return (v == LAST) ? '0 : v + 1'b1;
  endfunction

  always_comb begin
    stage_adv = '0;
    stage_adv[0] = step && !set_mode && (num_wheels != '0);
    for (int k = 1; k < NUM_ROT; k++)
      stage_adv[k] = stage_adv[k-1] && (CNT_W'(k) < num_wheels) &&
                     (pos_q[wheel_ord[(k-1)*IDX_W +: IDX_W]] == LAST);
    rot_adv = '0;
    for (int k = 0; k < NUM_ROT; k++)
      if (stage_adv[k]) rot_adv[wheel_ord[k*IDX_W +: IDX_W]] = 1'b1;
  end

  for (genvar r = 0; r < NUM_ROT; r++) begin : g_rot
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        pos_q[r] <= '0;
      else if (set_mode) begin
        if (set_wheel == IDX_W'(r)) begin
          if (!set_load)
            pos_q[r] <= bump(pos_q[r]);
          else if (set_pos < POS_W'(MODULUS))
            pos_q[r] <= set_pos;
        end
      end else if (rot_adv[r])
        pos_q[r] <= bump(pos_q[r]);
    end

    a_r10_pos_range: assert property (@(posedge clk) disable iff (!rst_n)
      pos_q[r] < POS_W'(MODULUS));
    a_r3_bad_load_kept: assert property (@(posedge clk) disable iff (!rst_n)
      set_mode && set_wheel == IDX_W'(r) && set_load && set_pos >= POS_W'(MODULUS)
      |=> $stable(pos_q[r]));
    a_r5_set_other_stable: assert property (@(posedge clk) disable iff (!rst_n)
      set_mode && set_wheel != IDX_W'(r) |=> $stable(pos_q[r]));
    a_r6_idle_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !set_mode && !step |=> $stable(pos_q[r]));
  end

  a_r4_set_advance: assert property (@(posedge clk) disable iff (!rst_n)
    set_mode && !set_load |=> pos_q[$past(set_wheel)] == bump($past(pos_q[set_wheel])));

  assign cur_wheel = wheel_ord[sel*IDX_W +: IDX_W];
  assign cur_pos   = pos_q[cur_wheel];
endmodule

// File: tb/tb_rotor_pos_counter.sv
`timescale 1ns/10ps
module tb_rotor_pos_counter;
  logic clk = 0, rst_n = 0;
  logic set_mode = 0, set_load = 0, step = 0;
  logic [1:0] set_wheel = 0, sel = 0;
  logic [4:0] set_pos = 0;
  logic [2:0] num_wheels = 4;
  logic [7:0] wheel_ord = 8'b11_10_01_00;
  logic [1:0] cur_wheel;
  logic [4:0] cur_pos;
  int checks = 0, fails = 0;
  bit done = 0;
  int exp_pos [4];

  rotor_pos_counter dut (.*);

  always #2 clk = ~clk;

  function automatic int ord_at(input int k);
    return int'(wheel_ord[k*2 +: 2]);
  endfunction

  task automatic expect_eq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic sweep(input string tag);
    for (int s = 0; s < 4; s++) begin
      sel = 2'(s);
      #0.2;
      expect_eq("R9 cur_wheel", int'(cur_wheel), ord_at(s));
      expect_eq(tag, int'(cur_pos), exp_pos[ord_at(s)]);
    end
  endtask

  task automatic cycle(input string tag);
    int nxt [4];
    bit carry;
    nxt = exp_pos;
    if (set_mode) begin
      if (!set_load) nxt[set_wheel] = (exp_pos[set_wheel] + 1) % 26;
      else if (set_pos < 26) nxt[set_wheel] = int'(set_pos);
    end else begin
      carry = step && num_wheels != 0;
      for (int k = 0; k < 4; k++) begin
        if (!carry || k >= int'(num_wheels)) break;
        carry = exp_pos[ord_at(k)] == 25;
        nxt[ord_at(k)] = (exp_pos[ord_at(k)] + 1) % 26;
      end
    end
    @(posedge clk);
    exp_pos = nxt;
    #1;
    sweep(tag);
    @(negedge clk);
  endtask

  task automatic load(input int w, input int v, input string tag);
    set_mode = 1; set_load = 1; set_wheel = 2'(w); set_pos = 5'(v);
    cycle(tag);
  endtask

  task automatic shuffle_ord();
    int a [4];
    int j, t;
    for (int i = 0; i < 4; i++) a[i] = i;
    for (int i = 3; i > 0; i--) begin
      j = $urandom_range(i, 0); t = a[i]; a[i] = a[j]; a[j] = t;
    end
    for (int i = 0; i < 4; i++) wheel_ord[i*2 +: 2] = 2'(a[i]);
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed1234));
    foreach (exp_pos[i]) exp_pos[i] = 0;
    #1; sweep("R1 reset");
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);

    for (int r = 0; r < 4; r++) load(r, 25 - r, "R2 load");
    load(2, 26, "R3 load 26 kept");
    load(1, 31, "R3 load 31 kept");
    set_load = 0; set_wheel = 3;
    repeat (30) cycle("R4 set advance wraps");
    step = 1; set_load = 1; set_pos = 31;
    repeat (3) cycle("R5 step ignored in set");
    step = 0;

    for (int r = 0; r < 4; r++) load(r, 25, "R2 load");
    set_mode = 0; num_wheels = 4; wheel_ord = 8'b00_01_11_10;
    step = 1; cycle("R7 full ripple");
    step = 0; cycle("R6 no step holds");
    for (int r = 0; r < 4; r++) load(r, 25, "R2 load");
    set_mode = 0; num_wheels = 2; step = 1;
    cycle("R8 ripple limited to two stages");
    num_wheels = 0;
    repeat (3) cycle("R8 zero wheels");
    num_wheels = 1;
    repeat (27) cycle("R6 single stage steps");
    step = 0;

    for (int i = 0; i < 4000; i++) begin
      if ($urandom_range(99, 0) < 3) shuffle_ord();
      set_mode = ($urandom_range(9, 0) < 3);
      set_wheel = 2'($urandom);
      set_load = 1'($urandom);
      set_pos = ($urandom_range(9, 0) < 8) ? 5'($urandom_range(25, 0)) : 5'($urandom_range(31, 26));
      step = ($urandom_range(9, 0) < 6);
      num_wheels = 3'($urandom_range(4, 0));
      if (!set_mode && $urandom_range(9, 0) == 0)
        exp_pos[ord_at(0)] = exp_pos[ord_at(0)];
      cycle(set_mode ? "R2 random set" : "R7 random encode");
    end
    step = 0;
    rst_n = 0;
    foreach (exp_pos[i]) exp_pos[i] = 0;
    #0.5; sweep("R1 reset midrun");
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule